// File: doc/BRIEF.md
# Bus Transaction Event Generator with Serial Issue

This block watches a stream of bus word transactions that an upstream decoder has already split out of bursts, one word per transaction. Each transaction has an access kind (port read or write, memory read or write, interrupt), an address and a data word. The block compares every transaction against a fixed table of event patterns. Each pattern names one access kind, a window of offsets measured from one of several programmable base registers, and a data mask together with an inclusive range for the masked data.

A single transaction can satisfy several patterns in the same cycle. The block keeps all of them and presents them on one event port, one per clock, lowest pattern index first. A downstream monitor therefore always sees a strictly serial trace. While more than one event is still waiting, the block lowers its ready output, and the upstream decoder must hold its transaction. No event is dropped.

Each event carries the data word of the transaction that raised it. It also carries the data word of the previous transaction that matched the same pattern, so a recovery handler can restore a register's earlier value. System software writes the base registers through a small configuration port at start-up.

The pattern table is fixed at build time:

| Index | Kind | Base | Offset window | Data mask | Masked data range |
|---|---|---|---|---|---|
| 0 | memory write | 0 | 0x220..0x220 | 0x1 | 1..1 |
| 1 | memory write | 0 | 0x220..0x220 | 0x1 | 0..0 |
| 2 | memory write | 0 | 0x220..0x22C | 0x0 | 0..0 |
| 3 | interrupt | 1 | 0x0..0x3 | 0xFF | 0x10..0x1F |

Top module: `bevt_gen`

## Requirements
- R1: After a synchronous reset, ev_valid is 0, txn_ready is 1, all base registers are 0, and all per-pattern shadow values are 0.
- R2: When cfg_we is 1 at a clock edge, base register cfg_idx takes the value cfg_data. Later matches use the new base.
- R3: A pattern matches only when txn_kind equals its kind exactly. The encodings are 0 for port read, 1 for port write, 2 for memory read, 3 for memory write and 4 for interrupt.
- R4: The address offset is txn_addr minus the selected base, computed modulo 2^32. It matches when it lies inside the pattern's inclusive offset window. An address below the base therefore never matches.
- R5: The data condition holds when (txn_data AND mask) lies inside the pattern's inclusive value range.
- R6: A transaction is accepted at a clock edge where txn_valid and txn_ready are both 1. Its first event appears on the ports right after that edge. Each event drives exactly one bit of ev_id (bit i for pattern i), and at most one event is shown per cycle.
- R7: The events of a transaction that matches several patterns appear in consecutive cycles, in ascending pattern index.
- R8: txn_ready is 0 while two or more events are still waiting. A transaction held on the input during that time is not accepted and is taken later, and every event is issued.
- R9: ev_data equals the data of the transaction that raised the event. ev_old equals the data of the previous accepted transaction that matched the same pattern, or 0 if there was none since reset.
- R10: An accepted transaction that matches no pattern produces no event and leaves every shadow value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Base register write strobe |
| cfg_idx | input | 1 | Base register select |
| cfg_data | input | 32 | Base register write value |
| txn_valid | input | 1 | Transaction present |
| txn_kind | input | 3 | Access kind code |
| txn_addr | input | 32 | Transaction address |
| txn_data | input | 32 | Transaction data word |
| txn_ready | output | 1 | Transaction may be accepted |
| ev_valid | output | 1 | An event is shown this cycle |
| ev_id | output | 4 | One-hot pattern index of the event |
| ev_data | output | 32 | Data of the triggering transaction |
| ev_old | output | 32 | Previous data matched by the same pattern |

## Verification
A corrupted pending-event mask shows up right after the accepting edge. Events come out missing, duplicated or out of order, or txn_ready stays low for a cycle too many or too few, and the bench compares each of these cycle by cycle. A wrong base register or pattern comparison shows as a missing or extra event in that same first cycle. A stale or misrouted shadow value does not appear until the next transaction that hits the same pattern, where ev_old carries the wrong word. The bench chains several such hits per pattern so that this fault is exposed.

// File: rtl/bevt_pkg.sv
package bevt_pkg;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int NBASE  = 2;
    localparam int NPAT   = 4;
    localparam int BSEL_W = (NBASE > 1) ? $clog2(NBASE) : 1;
    localparam int PID_W  = (NPAT > 1) ? $clog2(NPAT) : 1;

    typedef enum logic [2:0] {
        K_IO_RD  = 3'd0,
        K_IO_WR  = 3'd1,
        K_MEM_RD = 3'd2,
        K_MEM_WR = 3'd3,
        K_IRQ    = 3'd4
    } kind_t;

    typedef struct packed {
        kind_t             kind;
        logic [BSEL_W-1:0] bsel;
        logic [ADDR_W-1:0] off_lo;
        logic [ADDR_W-1:0] off_hi;
        logic [DATA_W-1:0] mask;
        logic [DATA_W-1:0] val_lo;
        logic [DATA_W-1:0] val_hi;
    } pat_t;

    // Fixed pattern table; an unused index gets an empty window.
    function automatic pat_t pat_table(input int idx);
        pat_t p;
        p = '{kind: K_IO_RD, bsel: '0, off_lo: ADDR_W'(1), off_hi: '0,
              mask: '0, val_lo: '0, val_hi: '0};
        case (idx)
            0: p = '{kind: K_MEM_WR, bsel: BSEL_W'(0), off_lo: ADDR_W'('h220),
                     off_hi: ADDR_W'('h220), mask: DATA_W'(1),
                     val_lo: DATA_W'(1), val_hi: DATA_W'(1)};
            1: p = '{kind: K_MEM_WR, bsel: BSEL_W'(0), off_lo: ADDR_W'('h220),
                     off_hi: ADDR_W'('h220), mask: DATA_W'(1),
                     val_lo: DATA_W'(0), val_hi: DATA_W'(0)};
            2: p = '{kind: K_MEM_WR, bsel: BSEL_W'(0), off_lo: ADDR_W'('h220),
                     off_hi: ADDR_W'('h22C), mask: DATA_W'(0),
                     val_lo: DATA_W'(0), val_hi: DATA_W'(0)};
            3: p = '{kind: K_IRQ, bsel: BSEL_W'(1), off_lo: ADDR_W'(0),
                     off_hi: ADDR_W'(3), mask: DATA_W'('hFF),
                     val_lo: DATA_W'('h10), val_hi: DATA_W'('h1F)};
            default: ;
        endcase
        return p;
    endfunction
endpackage

// File: rtl/bevt_match.sv
module bevt_match
    import bevt_pkg::*;
#(
    parameter int IDX = 0
) (
    input  kind_t                        txn_kind,
    input  logic [ADDR_W-1:0]            txn_addr,
    input  logic [DATA_W-1:0]            txn_data,
    input  logic [NBASE-1:0][ADDR_W-1:0] bases,
    output logic                         hit
);
    localparam pat_t PAT = pat_table(IDX);

    logic [ADDR_W-1:0] offset;
    logic [DATA_W-1:0] masked;
    logic              kind_ok, addr_ok, data_ok;

    always_comb begin
        offset  = txn_addr - bases[PAT.bsel];
        masked  = txn_data & PAT.mask;
        kind_ok = (txn_kind == PAT.kind);
        addr_ok = (offset >= PAT.off_lo) && (offset <= PAT.off_hi);
        data_ok = (masked >= PAT.val_lo) && (masked <= PAT.val_hi);
        hit     = kind_ok && addr_ok && data_ok;
    end
endmodule

// File: rtl/bevt_seq.sv
module bevt_seq
    import bevt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [NPAT-1:0]  load_mask,
    output logic             ev_valid,
    output logic [NPAT-1:0]  ev_onehot,
    output logic [PID_W-1:0] ev_idx,
    output logic             ready
);
    logic [NPAT-1:0] pend_q;
    logic [NPAT-1:0] lowest;

    always_comb begin
        lowest    = pend_q & (~pend_q + NPAT'(1));
        ev_valid  = |pend_q;
        ev_onehot = lowest;
        ready     = ((pend_q & ~lowest) == '0);
        ev_idx    = '0;
        for (int i = 0; i < NPAT; i++) begin
            if (lowest[i]) ev_idx = PID_W'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else if (load) begin
            pend_q <= load_mask;
        end else begin
            pend_q <= pend_q & ~lowest;
        end
    end

    // R6: a shown event names exactly one pattern
    a_r6_onehot: assert property (@(posedge clk) disable iff (rst)
        ev_valid |-> $onehot(ev_onehot));

    // R7: without a new load, the next event has a higher index
    a_r7_ascending: assert property (@(posedge clk) disable iff (rst)
        (ev_valid && $past(ev_valid) && !$past(load)) |-> (ev_onehot > $past(ev_onehot)));

    // R8: holding off input means more events are still queued
    a_r8_busy_drains: assert property (@(posedge clk) disable iff (rst)
        !ready |=> ev_valid);
endmodule

// File: rtl/bevt_gen.sv
module bevt_gen
    import bevt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [BSEL_W-1:0] cfg_idx,
    input  logic [31:0]       cfg_data,
    input  logic              txn_valid,
    input  logic [2:0]        txn_kind,
    input  logic [31:0]       txn_addr,
    input  logic [31:0]       txn_data,
    output logic              txn_ready,
    output logic              ev_valid,
    output logic [NPAT-1:0]   ev_id,
    output logic [31:0]       ev_data,
    output logic [31:0]       ev_old
);
    logic [NBASE-1:0][ADDR_W-1:0] base_q;
    logic [NPAT-1:0][DATA_W-1:0]  shadow_q;
    logic [NPAT-1:0][DATA_W-1:0]  old_q;
    logic [DATA_W-1:0]            data_q;
    logic [NPAT-1:0]              hits;
    logic [PID_W-1:0]             ev_idx;
    logic                         accept;
    kind_t                        kind_in;

    assign kind_in = kind_t'(txn_kind);
    assign accept  = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
        end else if (cfg_we) begin
            base_q[cfg_idx] <= cfg_data;
        end
    end

    for (genvar g = 0; g < NPAT; g++) begin : g_pat
        bevt_match #(.IDX(g)) u_match (
            .txn_kind (kind_in),
            .txn_addr (txn_addr),
            .txn_data (txn_data),
            .bases    (base_q),
            .hit      (hits[g])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= '0;
                old_q[g]    <= '0;
            end else if (accept && hits[g]) begin
                old_q[g]    <= shadow_q[g];
                shadow_q[g] <= txn_data;
            end
        end

        // R9: a matched transaction becomes that pattern's shadow
        a_r9_shadow_update: assert property (@(posedge clk) disable iff (rst)
            (accept && hits[g]) |=> (shadow_q[g] == $past(txn_data)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (accept) begin
            data_q <= txn_data;
        end
    end

    bevt_seq u_seq (
        .clk       (clk),
        .rst       (rst),
        .load      (accept),
        .load_mask (hits),
        .ev_valid  (ev_valid),
        .ev_onehot (ev_id),
        .ev_idx    (ev_idx),
        .ready     (txn_ready)
    );

    assign ev_data = data_q;
    assign ev_old  = old_q[ev_idx];

    // R2: a configuration write lands in the selected base register
    a_r2_base_write: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (base_q[$past(cfg_idx)] == $past(cfg_data)));

    // R10: an unmatched acceptance leaves no event behind
    a_r10_no_match_quiet: assert property (@(posedge clk) disable iff (rst)
        (accept && (hits == '0)) |=> !ev_valid);
endmodule

// File: tb/bevt_gen_test.sv
module bevt_gen_test;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [0:0]  cfg_idx = '0;
    logic [31:0] cfg_data = '0;
    logic        txn_valid = 1'b0;
    logic [2:0]  txn_kind = '0;
    logic [31:0] txn_addr = '0;
    logic [31:0] txn_data = '0;
    logic        txn_ready;
    logic        ev_valid;
    logic [3:0]  ev_id;
    logic [31:0] ev_data;
    logic [31:0] ev_old;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [31:0] sh [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    bevt_gen uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_data(cfg_data), .txn_valid(txn_valid), .txn_kind(txn_kind),
        .txn_addr(txn_addr), .txn_data(txn_data), .txn_ready(txn_ready),
        .ev_valid(ev_valid), .ev_id(ev_id), .ev_data(ev_data), .ev_old(ev_old)
    );

    task automatic check(input bit ok, input string req,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Present one transaction and compare the events it should raise (mask, ascending).
    task automatic send(input logic [2:0] k, input logic [31:0] a,
                        input logic [31:0] d, input logic [3:0] m, input string req);
        int left;
        @(negedge clk);
        while (!txn_ready) @(negedge clk);
        txn_valid = 1'b1; txn_kind = k; txn_addr = a; txn_data = d;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        left = $countones(m);
        if (m == 4'd0) begin
            check(!ev_valid, {req, " R10 no event"}, 64'(ev_valid), 64'd0);
        end
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                check(ev_valid && ev_id == 4'(1 << i), {req, " R6 R7 event id"},
                      64'(ev_id), 64'(1 << i));
                check(ev_data == d, {req, " R9 ev_data"}, 64'(ev_data), 64'(d));
                check(ev_old == sh[i], {req, " R9 ev_old"}, 64'(ev_old), 64'(sh[i]));
                check(txn_ready == (left <= 1), {req, " R8 ready"},
                      64'(txn_ready), 64'(left <= 1));
                sh[i] = d;
                left--;
                @(negedge clk);
            end
        end
        if (m != 4'd0) check(!ev_valid, {req, " R6 drained"}, 64'(ev_valid), 64'd0);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!ev_valid, "R1 ev_valid after reset", 64'(ev_valid), 64'd0);
        check(txn_ready, "R1 ready after reset", 64'(txn_ready), 64'd1);
    endtask

    task automatic t_config();
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 1'b0; cfg_data = 32'h1000_0000;
        @(negedge clk);
        cfg_idx = 1'b1; cfg_data = 32'h0000_2000;
        @(negedge clk);
        cfg_we = 1'b0;
        // R2: base 0 moved, so the raw offset no longer matches
        send(3'd3, 32'h0000_0220, 32'h1, 4'b0000, "R2 R4 below base");
    endtask

    task automatic t_enable_modify_disable();
        send(3'd3, 32'h1000_0220, 32'h1,  4'b0101, "R7 enable write");
        send(3'd3, 32'h1000_0228, 32'h45, 4'b0100, "R9 modify write");
        send(3'd3, 32'h1000_0220, 32'h0,  4'b0110, "R7 disable write");
    endtask

    task automatic t_kind();
        send(3'd2, 32'h1000_0220, 32'h1, 4'b0000, "R3 memory read");
        send(3'd1, 32'h1000_0220, 32'h1, 4'b0000, "R3 port write");
        send(3'd4, 32'h1000_0220, 32'h1, 4'b0000, "R3 interrupt kind");
    endtask

    task automatic t_window();
        send(3'd3, 32'h1000_022C, 32'h7, 4'b0100, "R4 upper edge");
        send(3'd3, 32'h1000_0230, 32'h7, 4'b0000, "R4 past upper edge");
        send(3'd3, 32'h1000_021C, 32'h7, 4'b0000, "R4 below lower edge");
    endtask

    task automatic t_data();
        send(3'd4, 32'h0000_2002, 32'h1F,  4'b1000, "R5 range top");
        send(3'd4, 32'h0000_2002, 32'h20,  4'b0000, "R5 above range");
        send(3'd4, 32'h0000_2002, 32'h0F,  4'b0000, "R5 below range");
        send(3'd4, 32'h0000_2003, 32'h110, 4'b1000, "R5 masked bits");
        send(3'd4, 32'h0000_2004, 32'h10,  4'b0000, "R4 irq window");
    endtask

    // R8: second transaction held on the input while two events wait.
    task automatic t_hold();
        @(negedge clk);
        while (!txn_ready) @(negedge clk);
        txn_valid = 1'b1; txn_kind = 3'd3; txn_addr = 32'h1000_0220; txn_data = 32'h3;
        @(posedge clk);
        @(negedge clk);
        check(!txn_ready, "R8 ready low with two pending", 64'(txn_ready), 64'd0);
        check(ev_valid && ev_id == 4'b0001, "R7 hold first event", 64'(ev_id), 64'h1);
        check(ev_old == sh[0], "R9 hold old p0", 64'(ev_old), 64'(sh[0]));
        sh[0] = 32'h3;
        txn_kind = 3'd4; txn_addr = 32'h0000_2000; txn_data = 32'h12;
        @(posedge clk);
        @(negedge clk);
        check(ev_valid && ev_id == 4'b0100, "R8 held txn not taken", 64'(ev_id), 64'h4);
        check(ev_data == 32'h3, "R9 hold data p2", 64'(ev_data), 64'h3);
        check(ev_old == sh[2], "R9 hold old p2", 64'(ev_old), 64'(sh[2]));
        sh[2] = 32'h3;
        check(txn_ready, "R8 ready back", 64'(txn_ready), 64'd1);
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0;
        check(ev_valid && ev_id == 4'b1000, "R8 held txn issued", 64'(ev_id), 64'h8);
        check(ev_data == 32'h12, "R9 held data", 64'(ev_data), 64'h12);
        check(ev_old == sh[3], "R9 held old p3", 64'(ev_old), 64'(sh[3]));
        sh[3] = 32'h12;
        @(negedge clk);
        check(!ev_valid, "R6 idle after hold", 64'(ev_valid), 64'd0);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) sh[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_config();
        t_enable_modify_disable();
        t_kind();
        t_window();
        t_data();
        t_hold();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule